// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block sits between decode and the out-of-order backend. Each cycle it accepts a group of up to two instructions, oldest in slot 0. Each slot carries two architectural source indices, one destination index and a flag that says whether the instruction writes a register. For every source the block returns the physical tag that holds its value. For every writing instruction it takes a fresh physical register from a FIFO free list and also returns the tag that the destination mapped to before. The retire stage later frees that old tag.

Two map tables are kept. The speculative table follows every renamed instruction. The committed table follows only retired instructions. A retire port writes the committed table and returns the displaced tag, which goes back to the tail of the free list. A recover pulse overwrites the speculative table with the committed one. It also moves the free-list read position back to where the retired instructions left it, so every tag taken on the wrong path can be handed out again.

Register 0 is never renamed: it always reads as physical tag 0, and naming it as a destination allocates nothing.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register n reads as physical tag n for every source. The first tags allocated are NARCH, NARCH+1, … in ascending order.
- R2: A slot that writes a non-zero destination gets the tag at the head of the free list. When both slots write, slot 0 gets the head and slot 1 gets the entry after it, and the two tags differ.
- R3: A slot with has-destination low, or with destination 0, consumes no free tag. Its destination and previous-tag outputs read 0.
- R4: A source of slot 1 that names slot 0's non-zero destination, while slot 0 writes, returns slot 0's new tag. A source naming register 0 returns tag 0.
- R5: The previous-tag output of a writing slot is the speculative mapping of its destination before this group. If slot 1 writes the same destination as a writing slot 0, its previous tag is slot 0's new tag.
- R6: The ready output is low, and the whole group is held, when the free list holds fewer tags than the group's writing slots need, or while recover is high. A held group changes no state.
- R7: A retire with a non-zero architectural index updates the committed table. It returns on the freed output, in the same cycle, the tag that the index held there before. That tag is appended to the free-list tail.
- R8: On recover, the speculative table becomes the committed table, including a retire presented in the same cycle. Tags allocated on the wrong path are handed out again, in the same order.
- R9: After an accepted group, later reads of a renamed destination return its new tag. When both slots write the same register, slot 1's tag remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 2 | Slot valid, bit 0 is the older slot |
| ren_has_dst | input | 2 | Slot writes a register |
| ren_src1 | input | 2x5 | First source index per slot |
| ren_src2 | input | 2x5 | Second source index per slot |
| ren_dst | input | 2x5 | Destination index per slot |
| ren_ready | output | 1 | Group accepted this cycle if any slot is valid |
| ren_psrc1 | output | 2x6 | Physical tag of first source |
| ren_psrc2 | output | 2x6 | Physical tag of second source |
| ren_pdst | output | 2x6 | Newly allocated destination tag, 0 if none |
| ren_pold | output | 2x6 | Previous mapping of destination, 0 if none |
| cmt_valid | input | 1 | Retire one writing instruction |
| cmt_arch | input | 5 | Retired destination index |
| cmt_phys | input | 6 | Retired instruction's allocated tag |
| cmt_freed | output | 6 | Tag released by this retire |
| recover | input | 1 | Discard speculative state |

## Verification
The bench builds the block with its default 32 architectural and 64 physical registers. That setting is small enough to sweep every architectural index at reset and to drain the whole 32-entry free list into a stall within a few dozen cycles. A long mixed run then draws indices mostly from registers 0 to 7. This keeps intra-group matches, same-destination pairs, retires in the same cycle as recovery, and recovery after deep wrong paths frequent. Every output is compared with a model computed from the requirements.

// File: rtl/rn_pkg.sv
package rn_pkg;

    localparam int ARCH_REGS = 32;
    localparam int PHYS_REGS = 64;
    localparam int GROUP     = 2;

    // A slot allocates only when valid, flagged as writing, and not register 0.
    function automatic logic slot_writes(logic vld, logic has_dst, int unsigned dst);
        return vld && has_dst && (dst != 0);
    endfunction

    function automatic logic [1:0] alloc_need(logic w0, logic w1);
        return {1'b0, w0} + {1'b0, w1};
    endfunction

endpackage

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NARCH = rn_pkg::ARCH_REGS,
    parameter int NPHYS = rn_pkg::PHYS_REGS,
    localparam int PW   = $clog2(NPHYS),
    localparam int PTW  = PW + 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [1:0]     pop_cnt,
    output logic [PW-1:0]  head0,
    output logic [PW-1:0]  head1,
    output logic [PTW-1:0] avail,
    input  logic           push_en,
    input  logic [PW-1:0]  push_tag,
    input  logic           commit_adv,
    input  logic           restore
);

    logic [PW-1:0]  slots [NPHYS];
    logic [PTW-1:0] rd_ptr, wr_ptr, cm_ptr, rd_ptr1, cm_next;

    assign rd_ptr1 = rd_ptr + PTW'(1);
    assign avail   = wr_ptr - rd_ptr;
    assign head0   = slots[rd_ptr[PW-1:0]];
    assign head1   = slots[rd_ptr1[PW-1:0]];
    assign cm_next = cm_ptr + PTW'(commit_adv);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++)
                slots[i] <= (i < NPHYS - NARCH) ? PW'(NARCH + i) : '0;
            rd_ptr <= '0;
            cm_ptr <= '0;
            wr_ptr <= PTW'(NPHYS - NARCH);
        end else begin
            if (push_en)
                slots[wr_ptr[PW-1:0]] <= push_tag;
            wr_ptr <= wr_ptr + PTW'(push_en);
            cm_ptr <= cm_next;
            rd_ptr <= restore ? cm_next : rd_ptr + PTW'(pop_cnt);
        end
    end

    // R6: allocation never takes more tags than are held
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
        PTW'(pop_cnt) <= avail);

    // R7: a freed tag always finds room
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        push_en |-> (avail < PTW'(NPHYS)));

endmodule

// File: rtl/rn_spec_map.sv
module rn_spec_map #(
    parameter int NARCH = rn_pkg::ARCH_REGS,
    parameter int NPHYS = rn_pkg::PHYS_REGS,
    parameter int NRD   = 6,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_idx [NRD],
    output logic [PW-1:0] rd_tag [NRD],
    input  logic          wr_en  [rn_pkg::GROUP],
    input  logic [AW-1:0] wr_idx [rn_pkg::GROUP],
    input  logic [PW-1:0] wr_tag [rn_pkg::GROUP],
    input  logic          restore,
    input  logic [PW-1:0] image  [NARCH]
);

    logic [PW-1:0] map_q [NARCH];

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_tag[r] = map_q[rd_idx[r]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NARCH; i++)
                map_q[i] <= PW'(i);
        end else if (restore) begin
            for (int i = 0; i < NARCH; i++)
                map_q[i] <= image[i];
        end else begin
            // younger slot written last so it wins a same-index conflict
            for (int s = 0; s < rn_pkg::GROUP; s++)
                if (wr_en[s])
                    map_q[wr_idx[s]] <= wr_tag[s];
        end
    end

endmodule

// File: rtl/rn_group_bypass.sv
module rn_group_bypass #(
    parameter int AW = 5,
    parameter int PW = 6
) (
    input  logic          older_wr,
    input  logic [AW-1:0] older_dst,
    input  logic [PW-1:0] older_tag,
    input  logic [AW-1:0] arch_idx,
    input  logic [PW-1:0] table_tag,
    output logic [PW-1:0] tag
);

    always_comb begin
        if (older_wr && (arch_idx == older_dst))
            tag = older_tag;
        else
            tag = table_tag;
    end

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int NARCH = rn_pkg::ARCH_REGS,
    parameter int NPHYS = rn_pkg::PHYS_REGS,
    localparam int AW   = $clog2(NARCH),
    localparam int PW   = $clog2(NPHYS),
    localparam int PTW  = PW + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          ren_valid,
    input  logic [1:0]          ren_has_dst,
    input  logic [1:0][AW-1:0]  ren_src1,
    input  logic [1:0][AW-1:0]  ren_src2,
    input  logic [1:0][AW-1:0]  ren_dst,
    output logic                ren_ready,
    output logic [1:0][PW-1:0]  ren_psrc1,
    output logic [1:0][PW-1:0]  ren_psrc2,
    output logic [1:0][PW-1:0]  ren_pdst,
    output logic [1:0][PW-1:0]  ren_pold,
    input  logic                cmt_valid,
    input  logic [AW-1:0]       cmt_arch,
    input  logic [PW-1:0]       cmt_phys,
    output logic [PW-1:0]       cmt_freed,
    input  logic                recover
);

    import rn_pkg::*;

    localparam int NRD = 3 * GROUP;

    logic [1:0]     wr;
    logic [1:0]     need;
    logic           fire;
    logic [PTW-1:0] avail;
    logic [PW-1:0]  head0, head1;
    logic [PW-1:0]  new_tag [GROUP];

    logic [AW-1:0]  rd_idx [NRD];
    logic [PW-1:0]  rd_tag [NRD];
    logic           sm_we  [GROUP];
    logic [AW-1:0]  sm_wi  [GROUP];

    logic [PW-1:0]  cmap [NARCH];
    logic [PW-1:0]  cmap_img [NARCH];
    logic           cm_we;
    logic [PW-1:0]  cm_old;

    // ---------------- group decode and allocation ----------------
    for (genvar s = 0; s < GROUP; s++) begin : g_slot
        assign wr[s]              = slot_writes(ren_valid[s], ren_has_dst[s], int'(ren_dst[s]));
        assign rd_idx[3*s + 0]    = ren_src1[s];
        assign rd_idx[3*s + 1]    = ren_src2[s];
        assign rd_idx[3*s + 2]    = ren_dst[s];
        assign sm_we[s]           = fire && wr[s];
        assign sm_wi[s]           = ren_dst[s];
        assign ren_pdst[s]        = wr[s] ? new_tag[s] : '0;
    end

    assign need      = alloc_need(wr[0], wr[1]);
    assign ren_ready = !recover && (avail >= PTW'(need));
    assign fire      = ren_ready && (ren_valid != 2'b00);

    assign new_tag[0] = head0;
    assign new_tag[1] = wr[0] ? head1 : head0;

    rn_free_list #(.NARCH(NARCH), .NPHYS(NPHYS)) free_i (
        .clk        (clk),
        .rst        (rst),
        .pop_cnt    (fire ? need : 2'd0),
        .head0      (head0),
        .head1      (head1),
        .avail      (avail),
        .push_en    (cm_we),
        .push_tag   (cm_old),
        .commit_adv (cm_we),
        .restore    (recover)
    );

    rn_spec_map #(.NARCH(NARCH), .NPHYS(NPHYS), .NRD(NRD)) spec_i (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (rd_idx),
        .rd_tag  (rd_tag),
        .wr_en   (sm_we),
        .wr_idx  (sm_wi),
        .wr_tag  (new_tag),
        .restore (recover),
        .image   (cmap_img)
    );

    // ---------------- intra-group forwarding for the younger slot ----------------
    logic [PW-1:0] y_tag [3];

    for (genvar k = 0; k < 3; k++) begin : g_byp
        rn_group_bypass #(.AW(AW), .PW(PW)) byp_i (
            .older_wr  (wr[0]),
            .older_dst (ren_dst[0]),
            .older_tag (new_tag[0]),
            .arch_idx  (rd_idx[3 + k]),
            .table_tag (rd_tag[3 + k]),
            .tag       (y_tag[k])
        );
    end

    assign ren_psrc1[0] = rd_tag[0];
    assign ren_psrc2[0] = rd_tag[1];
    assign ren_pold[0]  = wr[0] ? rd_tag[2] : '0;
    assign ren_psrc1[1] = y_tag[0];
    assign ren_psrc2[1] = y_tag[1];
    assign ren_pold[1]  = wr[1] ? y_tag[2] : '0;

    // ---------------- committed map and retire port ----------------
    assign cm_we     = cmt_valid && (cmt_arch != '0);
    assign cm_old    = cmap[cmt_arch];
    assign cmt_freed = cm_we ? cm_old : '0;

    always_comb begin
        for (int i = 0; i < NARCH; i++)
            cmap_img[i] = (cm_we && (cmt_arch == AW'(i))) ? cmt_phys : cmap[i];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NARCH; i++)
                cmap[i] <= PW'(i);
        end else if (cm_we) begin
            cmap[cmt_arch] <= cmt_phys;
        end
    end

    // R2: two writers in one group never share a tag
    a_r2_distinct_tags: assert property (@(posedge clk) disable iff (rst)
        (fire && wr[0] && wr[1]) |-> (ren_pdst[0] != ren_pdst[1]));

    // R4: register 0 reads as tag 0 in the younger slot
    a_r4_zero_source: assert property (@(posedge clk) disable iff (rst)
        (ren_valid[1] && ren_src1[1] == '0) |-> (ren_psrc1[1] == '0));

    // R3: a non-writing slot reports no tags
    a_r3_nodst_zero: assert property (@(posedge clk) disable iff (rst)
        (ren_valid[0] && !ren_has_dst[0]) |-> (ren_pdst[0] == '0 && ren_pold[0] == '0));

    // R7: a retire of a real register never frees tag 0
    a_r7_freed_nonzero: assert property (@(posedge clk) disable iff (rst)
        cm_we |-> (cmt_freed != '0));

endmodule

// File: tb/rename_unit_tb_top.sv
module rename_unit_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0]      v, h;
    logic [1:0][4:0] s1, s2, d;
    logic            ready;
    logic [1:0][5:0] ps1, ps2, pd, po;
    logic            cv;
    logic [4:0]      ca;
    logic [5:0]      cp;
    logic [5:0]      freed;
    logic            rec;

    rename_unit dut_i (
        .clk(clk), .rst(rst),
        .ren_valid(v), .ren_has_dst(h), .ren_src1(s1), .ren_src2(s2), .ren_dst(d),
        .ren_ready(ready), .ren_psrc1(ps1), .ren_psrc2(ps2), .ren_pdst(pd), .ren_pold(po),
        .cmt_valid(cv), .cmt_arch(ca), .cmt_phys(cp), .cmt_freed(freed),
        .recover(rec)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // requirement-level model
    int sm [32];
    int cm [32];
    int fq [64];
    int rp, wp, crp;
    int rob_a [64];
    int rob_p [64];
    int rh, rt;

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic step(logic [1:0] iv, logic [1:0] ih,
                        int a10, int a20, int ad0, int a11, int a21, int ad1,
                        bit want_c, bit irec, string note);
        int a1 [2];
        int a2 [2];
        int ad [2];
        bit wrs [2];
        int nd, t0, t1, e;
        bit rdy, fire, dc;
        int old;
        a1[0] = a10; a1[1] = a11; a2[0] = a20; a2[1] = a21; ad[0] = ad0; ad[1] = ad1;
        @(negedge clk);
        v = iv; h = ih;
        for (int s = 0; s < 2; s++) begin
            s1[s] = 5'(a1[s]); s2[s] = 5'(a2[s]); d[s] = 5'(ad[s]);
        end
        dc = want_c && (rt > rh);
        cv = dc;
        ca = dc ? 5'(rob_a[rh % 64]) : 5'd0;
        cp = dc ? 6'(rob_p[rh % 64]) : 6'd0;
        rec = irec;
        #5;
        for (int s = 0; s < 2; s++) wrs[s] = iv[s] && ih[s] && (ad[s] != 0);
        nd   = int'(wrs[0]) + int'(wrs[1]);
        rdy  = !irec && ((wp - rp) >= nd);
        fire = rdy && (iv != 2'b00);
        chk({"R6 ready ", note}, int'(ready), int'(rdy));
        t0 = wrs[0] ? fq[rp % 64] : 0;
        t1 = wrs[1] ? fq[(rp + int'(wrs[0])) % 64] : 0;
        if (fire) begin
            if (iv[0]) begin
                chk({"R9 slot0 src1 ", note}, int'(ps1[0]), sm[a10]);
                chk({"R9 slot0 src2 ", note}, int'(ps2[0]), sm[a20]);
                chk({"R2 slot0 dst ", note}, int'(pd[0]), t0);
                chk({"R5 slot0 old ", note}, int'(po[0]), wrs[0] ? sm[ad0] : 0);
            end
            if (iv[1]) begin
                e = (wrs[0] && a11 == ad0) ? t0 : sm[a11];
                chk({"R4 slot1 src1 ", note}, int'(ps1[1]), e);
                e = (wrs[0] && a21 == ad0) ? t0 : sm[a21];
                chk({"R4 slot1 src2 ", note}, int'(ps2[1]), e);
                chk({"R2 slot1 dst ", note}, int'(pd[1]), t1);
                e = wrs[1] ? ((wrs[0] && ad1 == ad0) ? t0 : sm[ad1]) : 0;
                chk({"R5 slot1 old ", note}, int'(po[1]), e);
            end
        end
        if (dc) begin
            old = cm[rob_a[rh % 64]];
            chk({"R7 freed ", note}, int'(freed), old);
            cm[rob_a[rh % 64]] = rob_p[rh % 64];
            fq[wp % 64] = old;
            wp++; crp++; rh++;
        end
        if (irec) begin
            for (int i = 0; i < 32; i++) sm[i] = cm[i];
            rp = crp;
            rt = rh;
        end else if (fire) begin
            if (wrs[0]) begin sm[ad0] = t0; rob_a[rt % 64] = ad0; rob_p[rt % 64] = t0; rt++; end
            if (wrs[1]) begin sm[ad1] = t1; rob_a[rt % 64] = ad1; rob_p[rt % 64] = t1; rt++; end
            rp += nd;
        end
        @(posedge clk);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        v = '0; h = '0; s1 = '0; s2 = '0; d = '0; cv = 0; ca = '0; cp = '0; rec = 0;
        for (int i = 0; i < 32; i++) begin sm[i] = i; cm[i] = i; end
        for (int i = 0; i < 64; i++) fq[i] = (i < 32) ? 32 + i : 0;
        rp = 0; wp = 32; crp = 0; rh = 0; rt = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: identity map across every index
        for (int k = 0; k < 16; k++) begin
            step(2'b11, 2'b00, 2*k, 31-2*k, 0, 2*k+1, 30-2*k, 0, 0, 0, "R1 sweep");
            chk("R1 reset map slot0", int'(ps1[0]), 2*k);
            chk("R1 reset map slot1", int'(ps1[1]), 2*k+1);
        end

        // R1/R2: drain the free list in ascending order, pairs with dependences
        for (int k = 0; k < 16; k++) begin
            step(2'b11, 2'b11, 2*k+1, 0, 2*k+1, 2*k+1, 5, (2*k+2) % 31 + 1, 0, 0, "R1 drain");
            chk("R1 ascending alloc", int'(pd[0]), 32 + 2*k);
        end

        // R6: empty list holds a writing group, lets a non-writing group through
        step(2'b01, 2'b01, 1, 2, 3, 0, 0, 0, 0, 0, "R6 stall");
        chk("R6 stalled when empty", int'(ready), 0);
        step(2'b11, 2'b00, 1, 2, 3, 4, 5, 6, 0, 0, "R6 no dest");

        // R3: destination 0 and has_dst low allocate nothing
        step(2'b11, 2'b10, 3, 4, 7, 5, 6, 0, 0, 0, "R3 r0 dest");
        chk("R3 r0 dest tag", int'(pd[1]), 0);

        // R8: recover with no retires reissues the same tags
        step(2'b00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 1, "R8 recover");
        step(2'b01, 2'b01, 4, 0, 4, 0, 0, 0, 0, 0, "R8 reissue");
        chk("R8 first tag reissued", int'(pd[0]), 32);
        chk("R8 map restored", int'(ps1[0]), 4);

        // R5/R9: same destination in both slots, then read it back
        step(2'b11, 2'b11, 6, 6, 6, 6, 6, 6, 0, 0, "R5 same dst");
        step(2'b01, 2'b00, 6, 6, 0, 0, 0, 0, 0, 0, "R9 readback");

        // mixed run: retires, recoveries and frequent dependences
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [1:0] iv, ih;
            r  = $urandom;
            iv = 2'(r);
            ih = (r[3:2] != 0) ? 2'b11 : 2'(r >> 4);
            step(iv, ih,
                 $urandom % 8, $urandom % 8, (r[6]) ? $urandom % 32 : $urandom % 8,
                 $urandom % 8, $urandom % 8, $urandom % 8,
                 ($urandom % 5) < 2, ($urandom % 40) == 0, "mixed");
        end

        @(negedge clk);
        v = '0; cv = 0; rec = 0;
        finish_up();
    end

endmodule